// File: doc/BRIEF.md
# Three-Wire Lane Burst Sequencer

This block sequences a single three-wire lane whose clock is embedded in the symbol stream. It works at the symbol level. While nothing is pending it rests in a low-power state with all three single-ended wires high. When a symbol is offered, it steps the wires down in two timed stages and turns on the high-speed path. It then sends a preamble made of the constant symbol 3 and a fixed seven-symbol sync word. After that it passes the caller's payload symbols one per clock. It closes the burst with a run of the constant symbol 4 and then puts the wires back to the all-high rest state.

Symbols are 3-bit values in the range 0 to 4. Each value names a wire-state transition, so every symbol slot changes the line. The caller offers symbols through a valid/ready pair and marks the final symbol of a burst with a last flag. Three runtime lengths, counted in symbol clocks, set:
- how long each low-power step lasts,
- how many preamble symbols are sent,
- how many closing symbols are sent.

Mapping data words to symbols, the line drivers and clock recovery all sit outside this block. Every lane output is registered. An asynchronous active-low reset clears the block at once, and its release is synchronised to the clock.

Top module: `tri_lane_burst_seq`

## Requirements
- R1: After reset, and whenever no burst is running, `lp_wire` is 3'b111, `hs_en` is 0, `hs_sym` is 0, `sym_err` is 0 and `sym_ready` is 0. Asserting `rst_n` low forces these values without waiting for a clock edge.
- R2: A burst begins when `sym_valid` is high in the rest state. The lane outputs then show `lp_wire` = 3'b011 for N cycles, followed by 3'b000 for N cycles, with `hs_en` low throughout. N is `cfg_lp_len`, and a value of 0 counts as 1.
- R3: After the low-power steps, `hs_en` goes high and `hs_sym` carries the value 3 for `cfg_pre_len` cycles. A value of 0 counts as 1.
- R4: The preamble is followed directly by the seven sync symbols 3, 4, 4, 4, 4, 4, 3, one per cycle.
- R5: `sym_ready` is high only in the payload phase, and a symbol is taken only when `sym_valid` and `sym_ready` are both high. The symbol taken appears on `hs_sym` one cycle after it is taken. Payload symbols leave in the order they were taken, with no gap after the sync word. Over a burst, `sym_ready` is high for exactly as many cycles as there are payload slots.
- R6: A payload cycle with `sym_valid` low sends the filler symbol 0 and keeps the burst open.
- R7: A taken symbol whose value is above 4 is sent as 0, and `sym_err` is high in the same output cycle. `hs_sym` never exceeds 4, and `sym_err` is only high while `hs_en` is high.
- R8: After the symbol taken with `sym_last` high, `hs_sym` carries 4 for `cfg_post_len` cycles. A value of 0 counts as 1. The lane then returns to the R1 state.
- R9: While `hs_en` is high, `lp_wire` is 3'b000. `lp_wire` only moves from 111 to 011, from 011 to 000, and from 000 back to 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| cfg_lp_len | input | CNT_W | Cycles spent in each low-power step (0 counts as 1) |
| cfg_pre_len | input | CNT_W | Number of preamble symbols (0 counts as 1) |
| cfg_post_len | input | CNT_W | Number of closing symbols (0 counts as 1) |
| sym_valid | input | 1 | Payload symbol offered; in the rest state it also requests a burst |
| sym_data | input | 3 | Payload symbol value, legal range 0 to 4 |
| sym_last | input | 1 | Marks the final payload symbol of a burst |
| sym_ready | output | 1 | High while the payload phase can take a symbol |
| lp_wire | output | 3 | Low-power levels of wires A, B, C (bit 2 is A) |
| hs_en | output | 1 | High-speed path enabled |
| hs_sym | output | 3 | Symbol sent in this cycle |
| sym_err | output | 1 | The symbol in this slot was out of range and was replaced |

## Verification
The bench drives bursts where every length is 0, which must behave as a length of one. A design that decrements from zero would instead stall in a step for hundreds of cycles. Payload streams include the values 5, 6 and 7 and a mid-burst gap in `sym_valid`. A design that forwards raw values, or closes the burst on a gap, breaks the expected slot-by-slot output stream. The count of ready cycles is checked against the number of payload slots, which catches a ready that leaks into the rest or preamble phases and swallows a symbol early. A reset is also applied in the middle of a preamble. The bench then checks that the wires return to all-high at once and that the next burst starts cleanly.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;

  localparam int SYM_W = 3;
  typedef logic [SYM_W-1:0] sym_t;

  // Symbol values with a fixed meaning on the lane
  localparam sym_t SYM_FILL = 3'd0;
  localparam sym_t SYM_PRE  = 3'd3;
  localparam sym_t SYM_POST = 3'd4;
  localparam sym_t SYM_TOP  = 3'd4;

  localparam int SYNC_LEN = 7;

  // Wire levels, bit 2 = A, bit 1 = B, bit 0 = C
  localparam logic [2:0] LP_REST  = 3'b111;
  localparam logic [2:0] LP_STEP1 = 3'b011;
  localparam logic [2:0] LP_STEP2 = 3'b000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STEP1,
    ST_STEP2,
    ST_PRE,
    ST_SYNC,
    ST_PAY,
    ST_POST
  } seq_st_e;

  // Sync word: value 3 at both ends, value 4 in between
  function automatic sym_t sync_sym(input int unsigned pos);
    return ((pos == 0) || (pos == SYNC_LEN - 1)) ? SYM_PRE : SYM_POST;
  endfunction

endpackage

// File: rtl/tlb_rst_sync.sv
`timescale 1ns/1ps
module tlb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      shift_q <= '0;
    end else begin
      shift_q <= {shift_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = shift_q[STAGES-1];

endmodule

// File: rtl/tlb_step_timer.sv
`timescale 1ns/1ps
module tlb_step_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_len,
  output logic [CNT_W-1:0] count,
  output logic             done
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // A length of zero is treated as one cycle
  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) begin
      cnt_d = (load_len == '0) ? '0 : (load_len - ONE);
    end else begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;
  assign done  = (cnt_q == '0);

endmodule

// File: rtl/tlb_seq_fsm.sv
`timescale 1ns/1ps
module tlb_seq_fsm
  import tlb_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_valid,
  input  logic             sym_last,
  input  logic [CNT_W-1:0] cfg_lp_len,
  input  logic [CNT_W-1:0] cfg_pre_len,
  input  logic [CNT_W-1:0] cfg_post_len,
  input  logic             step_done,
  output seq_st_e          state,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_len,
  output logic             sym_ready
);

  localparam logic [CNT_W-1:0] SYNC_CNT = CNT_W'(SYNC_LEN);

  seq_st_e st_q;
  seq_st_e st_d;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_len  = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (sym_valid) begin
          st_d     = ST_STEP1;
          tmr_load = 1'b1;
          tmr_len  = cfg_lp_len;
        end
      end
      ST_STEP1: begin
        if (step_done) begin
          st_d     = ST_STEP2;
          tmr_load = 1'b1;
          tmr_len  = cfg_lp_len;
        end
      end
      ST_STEP2: begin
        if (step_done) begin
          st_d     = ST_PRE;
          tmr_load = 1'b1;
          tmr_len  = cfg_pre_len;
        end
      end
      ST_PRE: begin
        if (step_done) begin
          st_d     = ST_SYNC;
          tmr_load = 1'b1;
          tmr_len  = SYNC_CNT;
        end
      end
      ST_SYNC: begin
        if (step_done) begin
          st_d = ST_PAY;
        end
      end
      ST_PAY: begin
        if (sym_valid && sym_last) begin
          st_d     = ST_POST;
          tmr_load = 1'b1;
          tmr_len  = cfg_post_len;
        end
      end
      ST_POST: begin
        if (step_done) begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign state     = st_q;
  assign sym_ready = (st_q == ST_PAY);

endmodule

// File: rtl/tlb_lane_out.sv
`timescale 1ns/1ps
module tlb_lane_out
  import tlb_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seq_st_e          state,
  input  logic [CNT_W-1:0] step_count,
  input  logic             sym_valid,
  input  sym_t             sym_data,
  output logic [2:0]       lp_wire,
  output logic             hs_en,
  output sym_t             hs_sym,
  output logic             sym_err
);

  localparam logic [CNT_W-1:0] SYNC_LAST = CNT_W'(SYNC_LEN - 1);

  logic [2:0]       lp_d;
  logic             hs_d;
  sym_t             sym_d;
  logic             err_d;
  logic             bad_sym;
  logic [CNT_W-1:0] sync_pos;

  assign bad_sym  = (sym_data > SYM_TOP);
  assign sync_pos = SYNC_LAST - step_count;

  always_comb begin
    lp_d  = LP_STEP2;
    hs_d  = 1'b1;
    sym_d = SYM_FILL;
    err_d = 1'b0;
    unique case (state)
      ST_IDLE: begin
        lp_d = LP_REST;
        hs_d = 1'b0;
      end
      ST_STEP1: begin
        lp_d = LP_STEP1;
        hs_d = 1'b0;
      end
      ST_STEP2: begin
        hs_d = 1'b0;
      end
      ST_PRE:  sym_d = SYM_PRE;
      ST_SYNC: sym_d = sync_sym(32'(sync_pos));
      ST_PAY: begin
        if (sym_valid) begin
          sym_d = bad_sym ? SYM_FILL : sym_data;
          err_d = bad_sym;
        end
      end
      ST_POST: sym_d = SYM_POST;
      default: begin
        lp_d = LP_REST;
        hs_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_wire <= LP_REST;
      hs_en   <= 1'b0;
      hs_sym  <= SYM_FILL;
      sym_err <= 1'b0;
    end else begin
      lp_wire <= lp_d;
      hs_en   <= hs_d;
      hs_sym  <= sym_d;
      sym_err <= err_d;
    end
  end

endmodule

// File: rtl/tri_lane_burst_seq.sv
`timescale 1ns/1ps
module tri_lane_burst_seq
  import tlb_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int RST_SYNC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_lp_len,
  input  logic [CNT_W-1:0] cfg_pre_len,
  input  logic [CNT_W-1:0] cfg_post_len,
  input  logic             sym_valid,
  input  logic [2:0]       sym_data,
  input  logic             sym_last,
  output logic             sym_ready,
  output logic [2:0]       lp_wire,
  output logic             hs_en,
  output logic [2:0]       hs_sym,
  output logic             sym_err
);

  logic             rst_core_n;
  seq_st_e          state;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_len;
  logic [CNT_W-1:0] tmr_count;
  logic             tmr_done;

  tlb_rst_sync #(.STAGES(RST_SYNC)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_core_n)
  );

  tlb_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (tmr_load),
    .load_len (tmr_len),
    .count    (tmr_count),
    .done     (tmr_done)
  );

  tlb_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .sym_valid    (sym_valid),
    .sym_last     (sym_last),
    .cfg_lp_len   (cfg_lp_len),
    .cfg_pre_len  (cfg_pre_len),
    .cfg_post_len (cfg_post_len),
    .step_done    (tmr_done),
    .state        (state),
    .tmr_load     (tmr_load),
    .tmr_len      (tmr_len),
    .sym_ready    (sym_ready)
  );

  tlb_lane_out #(.CNT_W(CNT_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .state      (state),
    .step_count (tmr_count),
    .sym_valid  (sym_valid),
    .sym_data   (sym_data),
    .lp_wire    (lp_wire),
    .hs_en      (hs_en),
    .hs_sym     (hs_sym),
    .sym_err    (sym_err)
  );

endmodule

// File: rtl/tlb_lane_checker.sv
`timescale 1ns/1ps
module tlb_lane_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sym_ready,
  input logic [2:0] lp_wire,
  input logic       hs_en,
  input logic [2:0] hs_sym,
  input logic       sym_err
);

  a_r9_lp_low_in_hs: assert property (@(posedge clk) disable iff (!rst_n)
    hs_en |-> (lp_wire == 3'b000));

  a_r9_rest_order: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_wire == 3'b111) |=> ((lp_wire == 3'b111) || (lp_wire == 3'b011)));

  a_r9_step_order: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_wire == 3'b011) |=> ((lp_wire == 3'b011) || (lp_wire == 3'b000)));

  a_r5_ready_in_hs: assert property (@(posedge clk) disable iff (!rst_n)
    sym_ready |-> hs_en);

  a_r7_sym_range: assert property (@(posedge clk) disable iff (!rst_n)
    hs_sym <= 3'd4);

  a_r7_err_replaced: assert property (@(posedge clk) disable iff (!rst_n)
    sym_err |-> (hs_en && (hs_sym == 3'd0)));

  a_r3_burst_opens_pre: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> (hs_sym == 3'd3));

  a_r8_burst_closes_post: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_en) |-> ((lp_wire == 3'b111) && ($past(hs_sym) == 3'd4)));

  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_en |-> ((hs_sym == 3'd0) && !sym_ready));

endmodule

bind tri_lane_burst_seq tlb_lane_checker u_lane_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .sym_ready (sym_ready),
  .lp_wire   (lp_wire),
  .hs_en     (hs_en),
  .hs_sym    (hs_sym),
  .sym_err   (sym_err)
);

// File: tb/tri_lane_burst_seq_bench.sv
`timescale 1ns/1ps
module tri_lane_burst_seq_bench;

  localparam int CW   = 8;
  localparam int NV   = 4;
  localparam int MAXE = 128;

  // Vector table: stimulus (lengths, payload count, seed, gap slot) and
  // expected number of cycles with hs_en high
  localparam int V_LP  [NV] = '{2, 0, 1, 3};
  localparam int V_PRE [NV] = '{3, 0, 1, 2};
  localparam int V_POST[NV] = '{2, 0, 1, 4};
  localparam int V_N   [NV] = '{6, 3, 10, 1};
  localparam int V_SEED[NV] = '{1, 5, 3, 2};
  localparam int V_GAP [NV] = '{-1, 1, 4, -1};
  localparam int V_TOT [NV] = '{18, 12, 19, 14};

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] cfg_lp_len, cfg_pre_len, cfg_post_len;
  logic          sym_valid, sym_last;
  logic [2:0]    sym_data;
  logic          sym_ready;
  logic [2:0]    lp_wire;
  logic          hs_en;
  logic [2:0]    hs_sym;
  logic          sym_err;

  int n_chk  = 0;
  int n_fail = 0;

  logic [7:0] exp_vec[MAXE];
  string      exp_tag[MAXE];
  int         n_exp;

  always #2.5 clk = ~clk;

  tri_lane_burst_seq #(.CNT_W(CW)) u_tri_lane_burst_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_lp_len(cfg_lp_len), .cfg_pre_len(cfg_pre_len), .cfg_post_len(cfg_post_len),
    .sym_valid(sym_valid), .sym_data(sym_data), .sym_last(sym_last),
    .sym_ready(sym_ready), .lp_wire(lp_wire), .hs_en(hs_en),
    .hs_sym(hs_sym), .sym_err(sym_err)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
    end
  endtask

  task automatic push(input logic [2:0] lp, input logic hs, input logic [2:0] s,
                      input logic e, input string t);
    exp_vec[n_exp] = {lp, hs, s, e};
    exp_tag[n_exp] = t;
    n_exp++;
  endtask

  function automatic logic [2:0] item_val(input int v, input int i);
    return 3'((i * 3 + V_SEED[v]) % 8);
  endfunction

  task automatic run_vec(input int v);
    int lpn, pren, postn, idx, rdy_cnt, hs_cnt;
    logic [7:0] act;
    logic rdy;
    lpn   = (V_LP[v]   == 0) ? 1 : V_LP[v];
    pren  = (V_PRE[v]  == 0) ? 1 : V_PRE[v];
    postn = (V_POST[v] == 0) ? 1 : V_POST[v];
    @(negedge clk);
    cfg_lp_len   = CW'(V_LP[v]);
    cfg_pre_len  = CW'(V_PRE[v]);
    cfg_post_len = CW'(V_POST[v]);
    n_exp = 0;
    push(3'b111, 1'b0, 3'd0, 1'b0, "R1");                 // rest before start
    push(3'b111, 1'b0, 3'd0, 1'b0, "R1");
    for (int j = 0; j < lpn; j++) push(3'b011, 1'b0, 3'd0, 1'b0, "R2");
    for (int j = 0; j < lpn; j++) push(3'b000, 1'b0, 3'd0, 1'b0, "R2");
    for (int j = 0; j < pren; j++) push(3'b000, 1'b1, 3'd3, 1'b0, "R3");
    for (int j = 0; j < 7; j++)
      push(3'b000, 1'b1, ((j == 0) || (j == 6)) ? 3'd3 : 3'd4, 1'b0, "R4");
    for (int i = 0; i < V_N[v]; i++) begin
      if (i == V_GAP[v]) push(3'b000, 1'b1, 3'd0, 1'b0, "R6");
      else if (item_val(v, i) > 3'd4) push(3'b000, 1'b1, 3'd0, 1'b1, "R7");
      else push(3'b000, 1'b1, item_val(v, i), 1'b0, "R5");
    end
    for (int j = 0; j < postn; j++) push(3'b000, 1'b1, 3'd4, 1'b0, "R8");
    push(3'b111, 1'b0, 3'd0, 1'b0, "R8");
    push(3'b111, 1'b0, 3'd0, 1'b0, "R8");
    idx = 0; rdy_cnt = 0; hs_cnt = 0;
    for (int k = 0; k < n_exp; k++) begin
      if (k > 0) @(negedge clk);
      act = {lp_wire, hs_en, hs_sym, sym_err};
      check(act == exp_vec[k], exp_tag[k], $sformatf("vec %0d slot %0d", v, k),
            int'(act), int'(exp_vec[k]));
      if (hs_en) hs_cnt++;
      rdy = sym_ready;
      if (rdy) rdy_cnt++;
      if (idx < V_N[v]) begin
        sym_valid = (idx != V_GAP[v]);
        sym_data  = item_val(v, idx);
        sym_last  = (idx == V_N[v] - 1);
      end else begin
        sym_valid = 1'b0;
        sym_data  = 3'd0;
        sym_last  = 1'b0;
      end
      if (rdy && (idx < V_N[v])) idx++;
    end
    check(rdy_cnt == V_N[v], "R5", $sformatf("vec %0d ready cycles", v), rdy_cnt, V_N[v]);
    check(hs_cnt == V_TOT[v], "R8", $sformatf("vec %0d hs cycles", v), hs_cnt, V_TOT[v]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    sym_valid = 1'b0; sym_data = 3'd0; sym_last = 1'b0;
    cfg_lp_len = CW'(1); cfg_pre_len = CW'(1); cfg_post_len = CW'(1);
    repeat (3) @(negedge clk);
    // R1: reset state
    check({lp_wire, hs_en, hs_sym, sym_err, sym_ready} == 9'b111_0_000_0_0, "R1",
          "reset outputs", int'({lp_wire, hs_en, hs_sym, sym_err, sym_ready}), 9'h1c0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check({lp_wire, hs_en, sym_ready} == 5'b111_0_0, "R1", "rest without request",
          int'({lp_wire, hs_en, sym_ready}), 5'h1c);

    for (int v = 0; v < NV; v++) begin
      run_vec(v);
      repeat (2) @(negedge clk);
    end

    // Directed: reset while the preamble is on the lane
    cfg_lp_len = CW'(1); cfg_pre_len = CW'(4); cfg_post_len = CW'(1);
    sym_valid = 1'b1; sym_data = 3'd1; sym_last = 1'b0;
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      if (hs_en) break;
    end
    check(hs_en && (lp_wire == 3'b000), "R9", "wires low in high-speed",
          int'({hs_en, lp_wire}), 4'h8);
    check(hs_sym == 3'd3, "R3", "first high-speed symbol", int'(hs_sym), 3);
    rst_n = 1'b0;
    #1;
    check({lp_wire, hs_en, hs_sym, sym_ready} == 8'b111_0_000_0, "R1",
          "asynchronous reset mid-burst", int'({lp_wire, hs_en, hs_sym, sym_ready}), 8'he0);
    sym_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_vec(3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule